// File: doc/BRIEF.md
# Dual-Output Serial Memory Read Slave

This block is the slave side of a serial-peripheral link that serves one command: a read that returns memory contents two bits per serial clock. The master lowers chip-select and shifts an 8-bit command code and then a 24-bit start address into the block on the single input line, one bit per rising clock edge, most significant bit first. Eight don't-care clocks follow. From then on the block drives each memory byte across two lines: the dedicated data-out line and the bidirectional data line, which until then has served as the input.

The serial pins are sampled by a system clock through synchronisers, so all state is in one clock domain with a synchronous reset. A byte-wide synchronous read port fetches from a backing memory with one cycle of latency. The next byte is fetched ahead of time, so the serial stream runs without gaps, and the read address counts up across the whole 24-bit space. Raising chip-select ends the transfer at any point, even partway through a byte.

Top module: `spi_dual_read_slave`

## Requirements
- R1: The block acts only on command code 8'h3B, received most significant bit first on `spi_io0_in` and sampled on rising `spi_sck` edges while `spi_cs_n` is low.
- R2: The 24 clocks after the command carry the start address, bit 23 first; the first byte returned is the memory byte at that address.
- R3: The clocks after the address are eight dummy clocks. Both output enables stay low during the command, address and dummy clocks. The first data bits are valid for the master to sample at the 41st rising edge.
- R4: Each data clock carries two bits. `spi_io1_out` carries D7, D5, D3, D1 in turn and `spi_io0_out` carries D6, D4, D2, D0 in turn, so one byte takes four clocks.
- R5: The output data values change only in response to a falling `spi_sck` edge. They stay stable through every high phase of the clock.
- R6: After each byte the read address increments by one, wrapping from 24'hFFFFFF to 24'h000000.
- R7: Raising `spi_cs_n` at any point, including mid-byte, drops both output enables within five system clocks. The next transaction then starts cleanly from its command code.
- R8: The transfer works with the clock idling low (mode 0) and with the clock idling high (mode 3).
- R9: After any other command code, the block keeps both output enables low and issues no memory read until `spi_cs_n` rises.
- R10: After synchronous reset, both output enables and `mem_rd_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst | input | 1 | Synchronous active-high reset |
| spi_cs_n | input | 1 | Chip-select, active low |
| spi_sck | input | 1 | Serial clock from the master |
| spi_io0_in | input | 1 | Input value of the bidirectional data line |
| spi_io0_out | output | 1 | Even data bit driven on the bidirectional line |
| spi_io0_oe | output | 1 | Drive enable for the bidirectional line |
| spi_io1_out | output | 1 | Odd data bit driven on the data-out line |
| spi_io1_oe | output | 1 | Drive enable for the data-out line |
| mem_rd_en | output | 1 | Read strobe to the backing memory |
| mem_rd_addr | output | 24 | Read address to the backing memory |
| mem_rd_data | input | 8 | Read data, valid one clock after the strobe |

## Verification
Assertions check on every cycle that the phase moves only on a rising edge, that an unknown command stays ignored, that the outputs are disabled outside the data phase and after chip-select rises, that the output values move only on falling edges, and that no read is issued while ignoring. Only the bench scenarios can show that the returned bytes match memory with the correct odd/even lane mapping in both clock modes. The same holds for the address wrap at the top of the space and for the partial-byte abort followed by a clean new transaction.

// File: rtl/spi_dor_pkg.sv
package spi_dor_pkg;
  typedef enum logic [2:0] {
    PH_OPC   = 3'd0,
    PH_ADDR  = 3'd1,
    PH_DUMMY = 3'd2,
    PH_DATA  = 3'd3,
    PH_SKIP  = 3'd4
  } phase_t;
endpackage

// File: rtl/spi_dor_sync.sv
module spi_dor_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= RST_VAL;
        else if (s == 0) chain[s] <= d;
        else chain[s] <= chain[(s == 0) ? 0 : s - 1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/spi_dor_cmd.sv
module spi_dor_cmd
  import spi_dor_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter logic [7:0] OPCODE = 8'h3B,
  parameter int DUMMY_CLKS = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_idle,
  input  logic              rise,
  input  logic              si,
  output phase_t            phase,
  output logic              addr_load,
  output logic [ADDR_W-1:0] addr
);
  localparam int CNT_W = $clog2(ADDR_W + DUMMY_CLKS + 9);

  logic [CNT_W-1:0]  cnt;
  logic [ADDR_W-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst || cs_idle) begin
      phase     <= PH_OPC;
      cnt       <= '0;
      sh        <= '0;
      addr_load <= 1'b0;
    end else begin
      addr_load <= 1'b0;
      if (rise) begin
        case (phase)
          PH_OPC: begin
            sh <= {sh[ADDR_W-2:0], si};
            if (cnt == CNT_W'(7)) begin
              cnt   <= '0;
              phase <= ({sh[6:0], si} == OPCODE) ? PH_ADDR : PH_SKIP;
            end else begin
              cnt <= cnt + CNT_W'(1);
            end
          end
          PH_ADDR: begin
            sh <= {sh[ADDR_W-2:0], si};
            if (cnt == CNT_W'(ADDR_W - 1)) begin
              cnt       <= '0;
              addr_load <= 1'b1;
              phase     <= (DUMMY_CLKS == 0) ? PH_DATA : PH_DUMMY;
            end else begin
              cnt <= cnt + CNT_W'(1);
            end
          end
          PH_DUMMY: begin
            if (cnt == CNT_W'(DUMMY_CLKS - 1)) begin
              cnt   <= '0;
              phase <= PH_DATA;
            end else begin
              cnt <= cnt + CNT_W'(1);
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign addr = sh;

  // R1: phase advances only on a sampled rising edge
  a_r1_phase_on_rise: assert property (@(posedge clk) disable iff (rst)
    (!rise && !cs_idle) |=> $stable(phase));

  // R9: an unknown command stays ignored until chip-select rises
  a_r9_skip_sticky: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_SKIP && !cs_idle) |=> (phase == PH_SKIP));
endmodule

// File: rtl/spi_dor_out.sv
module spi_dor_out #(
  parameter int ADDR_W = 24,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_idle,
  input  logic              fall,
  input  logic              in_data,
  input  logic              addr_load,
  input  logic [ADDR_W-1:0] addr,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              io0,
  output logic              io1,
  output logic              oe0,
  output logic              oe1
);
  localparam int SLOTS  = BYTE_W / 2;
  localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;

  logic [SLOT_W-1:0] slot;
  logic [ADDR_W-1:0] nxt;
  logic [BYTE_W-1:0] nbuf;
  logic [BYTE_W-1:0] sh;
  logic              rd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      slot <= '0; nxt <= '0; nbuf <= '0; sh <= '0; rd_q <= 1'b0;
      rd_en <= 1'b0; rd_addr <= '0;
      io0 <= 1'b0; io1 <= 1'b0; oe0 <= 1'b0; oe1 <= 1'b0;
    end else begin
      rd_en <= 1'b0;
      rd_q  <= rd_en;
      if (rd_q) nbuf <= rd_data;
      if (cs_idle) begin
        oe0  <= 1'b0;
        oe1  <= 1'b0;
        slot <= '0;
      end else if (addr_load) begin
        rd_en   <= 1'b1;
        rd_addr <= addr;
        nxt     <= addr + ADDR_W'(1);
        slot    <= '0;
      end else if (in_data && fall) begin
        oe0  <= 1'b1;
        oe1  <= 1'b1;
        slot <= (slot == SLOT_W'(SLOTS - 1)) ? '0 : slot + SLOT_W'(1);
        if (slot == '0) begin
          io1     <= nbuf[BYTE_W-1];
          io0     <= nbuf[BYTE_W-2];
          sh      <= {nbuf[BYTE_W-3:0], 2'b00};
          rd_en   <= 1'b1;
          rd_addr <= nxt;
          nxt     <= nxt + ADDR_W'(1);
        end else begin
          io1 <= sh[BYTE_W-1];
          io0 <= sh[BYTE_W-2];
          sh  <= {sh[BYTE_W-3:0], 2'b00};
        end
      end
    end
  end

  // R5: output values move only after a falling edge
  a_r5_change_on_fall: assert property (@(posedge clk) disable iff (rst)
    !fall |=> ($stable(io0) && $stable(io1)));

  // R7: releasing chip-select drops both drivers
  a_r7_release: assert property (@(posedge clk) disable iff (rst)
    cs_idle |=> (!oe0 && !oe1));
endmodule

// File: rtl/spi_dual_read_slave.sv
module spi_dual_read_slave
  import spi_dor_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int BYTE_W = 8,
  parameter logic [7:0] OPCODE = 8'h3B,
  parameter int DUMMY_CLKS = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              spi_cs_n,
  input  logic              spi_sck,
  input  logic              spi_io0_in,
  output logic              spi_io0_out,
  output logic              spi_io0_oe,
  output logic              spi_io1_out,
  output logic              spi_io1_oe,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic [BYTE_W-1:0] mem_rd_data
);
  logic [2:0]        pins_s;
  logic              cs_s, sck_s, si_s, sck_q;
  logic              rise, fall;
  phase_t            phase;
  logic              addr_load;
  logic [ADDR_W-1:0] addr;

  spi_dor_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst(rst),
    .d({spi_cs_n, spi_sck, spi_io0_in}),
    .q(pins_s)
  );

  assign cs_s  = pins_s[2];
  assign sck_s = pins_s[1];
  assign si_s  = pins_s[0];

  always_ff @(posedge clk) begin
    if (rst) sck_q <= 1'b0;
    else sck_q <= sck_s;
  end

  assign rise = sck_s & ~sck_q & ~cs_s;
  assign fall = ~sck_s & sck_q & ~cs_s;

  spi_dor_cmd #(.ADDR_W(ADDR_W), .OPCODE(OPCODE), .DUMMY_CLKS(DUMMY_CLKS)) u_cmd (
    .clk(clk), .rst(rst), .cs_idle(cs_s), .rise(rise), .si(si_s),
    .phase(phase), .addr_load(addr_load), .addr(addr)
  );

  spi_dor_out #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_out (
    .clk(clk), .rst(rst), .cs_idle(cs_s), .fall(fall),
    .in_data(phase == PH_DATA), .addr_load(addr_load), .addr(addr),
    .rd_en(mem_rd_en), .rd_addr(mem_rd_addr), .rd_data(mem_rd_data),
    .io0(spi_io0_out), .io1(spi_io1_out), .oe0(spi_io0_oe), .oe1(spi_io1_oe)
  );

  // R3: lines stay undriven outside the data phase
  a_r3_hiz_outside_data: assert property (@(posedge clk) disable iff (rst)
    (phase != PH_DATA) |-> (!spi_io0_oe && !spi_io1_oe));

  // R9: no memory access while ignoring a transaction
  a_r9_no_read_skip: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_SKIP) |-> !mem_rd_en);
endmodule

// File: tb/tb_spi_dual_read_slave.sv
module tb_spi_dual_read_slave;
  localparam int H = 6;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        spi_cs_n = 1'b1;
  logic        spi_sck = 1'b0;
  logic        spi_io0_in = 1'b0;
  logic        spi_io0_out, spi_io0_oe, spi_io1_out, spi_io1_oe;
  logic        mem_rd_en;
  logic [23:0] mem_rd_addr;
  logic [7:0]  mem_rd_data = 8'h00;

  int vectors = 0;
  int miscompares = 0;
  int rd_cnt = 0;
  bit done = 0;
  bit hiz_bad;

  always #10 clk = ~clk;

  spi_dual_read_slave dut (
    .clk(clk), .rst(rst), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck),
    .spi_io0_in(spi_io0_in), .spi_io0_out(spi_io0_out), .spi_io0_oe(spi_io0_oe),
    .spi_io1_out(spi_io1_out), .spi_io1_oe(spi_io1_oe),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data)
  );

  function automatic logic [7:0] mem_byte(input logic [23:0] a);
    return a[7:0] ^ {a[12:8], a[15:13]} ^ a[23:16] ^ 8'h5A;
  endfunction

  always @(posedge clk) begin
    if (mem_rd_en) begin
      mem_rd_data <= mem_byte(mem_rd_addr);
      rd_cnt <= rd_cnt + 1;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cmd_bit(input logic b);
    spi_sck <= 1'b0;
    spi_io0_in <= b;
    wait_clk(H);
    if (spi_io0_oe || spi_io1_oe) hiz_bad = 1;
    spi_sck <= 1'b1;
    wait_clk(H);
  endtask

  // one transaction: mode3 picks idle level, nbytes whole bytes then extra slots
  task automatic run_read(input bit mode3, input logic [7:0] opc, input logic [23:0] addr,
                          input int nbytes, input int extra, input string tag);
    int rd_before;
    bit ok_cmd;
    logic [7:0] got, exp;
    bit unstable;
    ok_cmd = (opc == 8'h3B);
    spi_sck <= mode3;
    wait_clk(4);
    spi_cs_n <= 1'b0;
    wait_clk(4);
    hiz_bad = 0;
    rd_before = rd_cnt;
    for (int i = 7; i >= 0; i--) cmd_bit(opc[i]);
    for (int i = 23; i >= 0; i--) cmd_bit(addr[i]);
    for (int i = 0; i < 8; i++) cmd_bit(1'($urandom));
    check(!hiz_bad, "R3 hi-Z during command/address/dummy", 32'(hiz_bad), 0);
    for (int k = 0; k < nbytes + 1; k++) begin
      int slots;
      slots = (k < nbytes) ? 4 : extra;
      if (slots == 0) break;
      got = 8'h00; unstable = 0;
      exp = mem_byte(addr + 24'(k));
      for (int p = 0; p < slots; p++) begin
        logic a1, a0;
        spi_sck <= 1'b0;
        wait_clk(H);
        if (ok_cmd && !(spi_io0_oe && spi_io1_oe)) unstable = 1;
        if (!ok_cmd && (spi_io0_oe || spi_io1_oe)) unstable = 1;
        a1 = spi_io1_out; a0 = spi_io0_out;
        got[7-2*p] = a1; got[6-2*p] = a0;
        spi_sck <= 1'b1;
        wait_clk(H/2);
        if (spi_io1_out !== a1 || spi_io0_out !== a0) unstable = 1;
        wait_clk(H - H/2);
        if (spi_io1_out !== a1 || spi_io0_out !== a0) unstable = 1;
      end
      if (ok_cmd) begin
        logic [7:0] mask;
        mask = 8'hFF << (8 - 2*slots);
        check(((got & mask) == (exp & mask)) && !unstable,
              (k == 0) ? tag : "R4 R6 byte lanes and address step",
              {23'd0, unstable, got & mask}, {24'd0, exp & mask});
      end else begin
        check(!unstable, "R9 ignored command leaves lines undriven", 32'(unstable), 0);
      end
    end
    if (!mode3) begin
      spi_sck <= 1'b0;
      wait_clk(H);
    end
    spi_cs_n <= 1'b1;
    wait_clk(5);
    check(!spi_io0_oe && !spi_io1_oe, "R7 release after chip-select",
          {30'd0, spi_io1_oe, spi_io0_oe}, 0);
    if (!ok_cmd)
      check(rd_cnt == rd_before, "R9 no memory read after unknown command",
            32'(rd_cnt - rd_before), 0);
    wait_clk(4);
  endtask

  initial begin
    logic [31:0] r;
    r = $urandom(32'h5EED_0042);
    wait_clk(5);
    rst <= 1'b0;
    wait_clk(3);
    check(!spi_io0_oe && !spi_io1_oe && !mem_rd_en && rd_cnt == 0, "R10 reset state",
          {29'd0, mem_rd_en, spi_io1_oe, spi_io0_oe}, 0);
    run_read(1'b0, 8'h3B, 24'h000010, 3, 0, "R1 R2 mode 0 first byte");
    run_read(1'b1, 8'h3B, 24'h123456, 4, 0, "R8 mode 3 first byte");
    run_read(1'b0, 8'h3B, 24'hFFFFFE, 4, 0, "R6 wrap start");
    run_read(1'b1, 8'h3B, 24'hFFFFFF, 2, 0, "R6 wrap top byte");
    run_read(1'b0, 8'h3B, 24'h00A0A0, 1, 2, "R7 partial byte abort");
    run_read(1'b1, 8'h3B, 24'h00A0A4, 2, 0, "R7 clean read after abort");
    run_read(1'b0, 8'h0B, 24'h001234, 2, 0, "R9");
    run_read(1'b1, 8'h3A, 24'h000000, 1, 0, "R9");
    run_read(1'b0, 8'h3B, 24'h000000, 2, 0, "R3 first data bits after dummy");
    for (int t = 0; t < 16; t++) begin
      logic [23:0] a;
      a = 24'($urandom);
      if ($urandom % 4 == 0) a = 24'hFFFFFF - 24'($urandom % 4);
      run_read(1'($urandom), 8'h3B, a, 1 + int'($urandom % 5), int'($urandom % 4),
               "R2 R4 R5 random read");
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule